// File: doc/BRIEF.md
# Power-On Boot and Reset Sequencer

This block runs the chip-level start-up order. A power-on reset, the active-low external reset pin or a brown-out detection (when brown-out detection is enabled) puts every core in a halted state and lets all I/O pins float. The slow internal oscillator is selected during this time. Once the reset cause goes away, the block waits a fixed settling window measured in slow-clock cycles. It then selects the fast clock and starts a bounded listening window for activity from a serial host.

If host activity is seen inside that window, the block hands control to the serial download path. If no activity is seen, it asks an external EEPROM reader for a byte stream and writes each byte, in order, into shared memory. When the last byte has been written, it releases core 0. If the reader reports an acknowledge failure, the block enters a shutdown state instead: all cores stay off and the pins stay floating.

All windows are parameters counted in cycles of whichever clock is selected at the time, so a bench can shorten them. The reset and host inputs are asynchronous and pass through a `SYNC_STAGES`-deep synchronizer.

Top module: `boot_sequencer`

## Requirements
- R1: While a reset cause is active, within SYNC_STAGES+1 clock edges of it appearing, the outputs settle to: core_en all 0, pin_float 1, clk_fast_sel 0, rd_req 0, mem_we 0, serial_sel 0, shut_down 0. A reset cause is rst high, ext_rst_n low, or bod_en and bod_low both high.
- R2: After the last reset cause is removed, clk_fast_sel rises exactly SYNC_STAGES+1+SETTLE_CYC clock edges later.
- R3: bod_low has no effect while bod_en is 0. While bod_en is 1, bod_low behaves like an asserted reset.
- R4: Suppose host_act goes high after edge F+d, where F is the edge at which clk_fast_sel rose, and stays high. If d+SYNC_STAGES is at most HOST_CYC-1, then serial_sel becomes 1 and pin_float becomes 0. In that case rd_req is never raised.
- R5: If no host activity reaches the listening window, rd_req rises exactly HOST_CYC edges after clk_fast_sel rose. Host activity after that point has no effect.
- R6: A byte is accepted at an edge where rd_req, rd_valid and not rd_err all hold. For the cycle after that edge, the block gives mem_we=1, mem_addr equal to the count of earlier accepted bytes (starting at 0), and mem_wdata equal to that byte. mem_we is 0 in every other cycle.
- R7: After MEM_BYTES bytes are accepted, rd_req drops at the accepting edge. core_en[0] rises one edge after the cycle that writes the last byte, and pin_float falls at the same edge. core_en[NCORES-1:1] stays 0.
- R8: rd_err with rd_valid on the first byte (no EEPROM present) gives shut_down=1, core_en=0, pin_float=1 and rd_req=0, with no memory write.
- R9: An acknowledge failure on any later byte also leads to the shutdown state, and core 0 is never released.
- R10: A reset cause arriving in any state, including during the load, returns the block to the hold state. The whole sequence then starts again from the settling window.
- R11: rd_valid presented while rd_req is 0 causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Currently selected system clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| bod_en | input | 1 | Brown-out detection enable |
| bod_low | input | 1 | Supply below brown-out threshold |
| host_act | input | 1 | Serial host activity seen on the download pins |
| rd_req | output | 1 | Request byte stream from the EEPROM reader |
| rd_valid | input | 1 | Reader presents a byte or an acknowledge failure |
| rd_data | input | 8 | Byte from the reader |
| rd_err | input | 1 | Reader acknowledge failure |
| mem_we | output | 1 | Shared memory write strobe |
| mem_addr | output | AW | Shared memory byte address |
| mem_wdata | output | 8 | Shared memory write data |
| clk_fast_sel | output | 1 | 1 selects the fast oscillator |
| core_en | output | NCORES | Per-core run enable |
| pin_float | output | 1 | 1 forces every I/O pin to input without pull-up |
| serial_sel | output | 1 | Serial download path has control |
| shut_down | output | 1 | No boot source found, chip idle |

## Verification
The assertions assume that rd_valid is a single-cycle strobe, and that the reader never presents data when rd_req is low unless the design is expected to ignore it. They also assume that ext_rst_n, once lowered, stays low for at least the synchronizer depth plus one cycle. The bench drives every input half a cycle away from the rising edge and keeps reset pulses longer than that minimum. It steps the host-activity arrival across every offset around the end of the listening window, so both sides of the boundary are exercised. It also injects acknowledge failures on the first byte and on a later byte, and a reset in the middle of a load.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_SETTLE,
        ST_LISTEN,
        ST_LOAD,
        ST_FINISH,
        ST_RUN,
        ST_SERIAL,
        ST_OFF
    } boot_state_e;

    typedef struct packed {
        logic fast_clk;
        logic float_pins;
        logic core0_go;
        logic eeprom_req;
        logic serial_go;
        logic off;
    } boot_ctrl_t;

    function automatic boot_ctrl_t decode_state(boot_state_e s);
        boot_ctrl_t c;
        c = '{fast_clk: 1'b1, float_pins: 1'b1, core0_go: 1'b0,
              eeprom_req: 1'b0, serial_go: 1'b0, off: 1'b0};
        case (s)
            ST_HOLD, ST_SETTLE: c.fast_clk   = 1'b0;
            ST_LOAD:            c.eeprom_req = 1'b1;
            ST_RUN: begin
                c.float_pins = 1'b0;
                c.core0_go   = 1'b1;
            end
            ST_SERIAL: begin
                c.float_pins = 1'b0;
                c.serial_go  = 1'b1;
            end
            ST_OFF:             c.off = 1'b1;
            default:            c.fast_clk = 1'b1;
        endcase
        return c;
    endfunction

    function automatic int unsigned larger(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boot_sync.sv
module boot_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/boot_window_timer.sv
module boot_window_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] last,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == last);
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader #(
    parameter int MEM_BYTES = 32768,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          rd_valid,
    input  logic          rd_err,
    input  logic [7:0]    rd_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          last_taken,
    output logic          abort
);
    localparam logic [AW-1:0] LAST_IDX = AW'(MEM_BYTES - 1);

    logic [AW-1:0] idx;
    logic          take;

    assign take       = active && rd_valid && !rd_err;
    assign abort      = active && rd_valid && rd_err;
    assign last_taken = take && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= take;
            if (take) begin
                mem_addr  <= idx;
                mem_wdata <= rd_data;
                idx       <= idx + 1'b1;
            end else if (!active) begin
                idx <= '0;
            end
        end
    end
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_seq_pkg::*;
#(
    parameter int NCORES      = 8,
    parameter int MEM_BYTES   = 32768,
    parameter int SETTLE_CYC  = 1000,
    parameter int HOST_CYC    = 3000000,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              bod_en,
    input  logic              bod_low,
    input  logic              host_act,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    input  logic              rd_err,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              clk_fast_sel,
    output logic [NCORES-1:0] core_en,
    output logic              pin_float,
    output logic              serial_sel,
    output logic              shut_down
);
    localparam int            WIN_MAX     = larger(SETTLE_CYC, HOST_CYC);
    localparam int            CW          = $clog2(WIN_MAX + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] HOST_LAST   = CW'(HOST_CYC - 1);

    boot_state_e state, state_nxt;
    boot_ctrl_t  ctrl;
    logic [1:0]  raw_in, sync_out;
    logic        hold, host_seen;
    logic        win_clear, win_done;
    logic [CW-1:0] win_last;
    logic        load_active, last_taken, load_abort;

    // Input conditioning: bit 1 = "no reset cause", bit 0 = host activity
    assign raw_in = {ext_rst_n && !(bod_en && bod_low), host_act};

    boot_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    assign hold      = !sync_out[1];
    assign host_seen = sync_out[0];

    // Window timer shared by settle and listen phases
    assign win_last  = (state == ST_SETTLE) ? SETTLE_LAST : HOST_LAST;
    assign win_clear = (state_nxt != state);

    boot_window_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (win_clear),
        .last    (win_last),
        .expired (win_done)
    );

    // Image copy path
    assign load_active = (state == ST_LOAD) && !hold;

    boot_image_loader #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_loader (
        .clk        (clk),
        .rst        (rst),
        .active     (load_active),
        .rd_valid   (rd_valid),
        .rd_err     (rd_err),
        .rd_data    (rd_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .last_taken (last_taken),
        .abort      (load_abort)
    );

    // Sequencing
    always_comb begin
        state_nxt = state;
        case (state)
            ST_HOLD:   state_nxt = ST_SETTLE;
            ST_SETTLE: if (win_done) state_nxt = ST_LISTEN;
            ST_LISTEN: begin
                if (host_seen)     state_nxt = ST_SERIAL;
                else if (win_done) state_nxt = ST_LOAD;
            end
            ST_LOAD: begin
                if (load_abort)      state_nxt = ST_OFF;
                else if (last_taken) state_nxt = ST_FINISH;
            end
            ST_FINISH: state_nxt = ST_RUN;
            default:   state_nxt = state;
        endcase
        if (hold) state_nxt = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nxt;
    end

    // Output decode
    assign ctrl         = decode_state(state);
    assign clk_fast_sel = ctrl.fast_clk;
    assign pin_float    = ctrl.float_pins;
    assign rd_req       = ctrl.eeprom_req;
    assign serial_sel   = ctrl.serial_go;
    assign shut_down    = ctrl.off;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        if (c == 0) begin : g_boot_core
            assign core_en[c] = ctrl.core0_go;
        end else begin : g_other_core
            assign core_en[c] = 1'b0;
        end
    end
endmodule

// File: rtl/boot_sequencer_chk.sv
module boot_sequencer_chk #(
    parameter int NCORES    = 8,
    parameter int MEM_BYTES = 32768,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_rst_n,
    input logic              rd_req,
    input logic              rd_valid,
    input logic              rd_err,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic              clk_fast_sel,
    input logic [NCORES-1:0] core_en,
    input logic              pin_float,
    input logic              serial_sel,
    input logic              shut_down
);
    a_r1_hold_safe: assert property (@(posedge clk) disable iff (rst)
        (!ext_rst_n && $past(!ext_rst_n) && $past(!ext_rst_n, 2) && $past(!ext_rst_n, 3))
        |-> (core_en == '0 && pin_float && !clk_fast_sel && !mem_we));

    a_r2_slow_clock_idle: assert property (@(posedge clk) disable iff (rst)
        !clk_fast_sel |-> (core_en == '0 && !rd_req && !serial_sel && !shut_down));

    a_r4_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({serial_sel, core_en[0], shut_down, rd_req}));

    a_r6_write_needs_accept: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(rd_req) && $past(rd_valid) && !$past(rd_err)));

    a_r7_core_after_last_write: assert property (@(posedge clk) disable iff (rst)
        $rose(core_en[0]) |-> ($past(mem_we) && $past(mem_addr) == AW'(MEM_BYTES - 1)));

    a_r8_off_is_safe: assert property (@(posedge clk) disable iff (rst)
        shut_down |-> (core_en == '0 && pin_float && !rd_req));
endmodule

bind boot_sequencer boot_sequencer_chk #(
    .NCORES    (NCORES),
    .MEM_BYTES (MEM_BYTES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_rst_n    (ext_rst_n),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .rd_err       (rd_err),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .clk_fast_sel (clk_fast_sel),
    .core_en      (core_en),
    .pin_float    (pin_float),
    .serial_sel   (serial_sel),
    .shut_down    (shut_down)
);

// File: tb/test_boot_sequencer.sv
module test_boot_sequencer;
    localparam int NCORES = 4;
    localparam int MEMB   = 16;
    localparam int SETTLE = 20;
    localparam int HOST   = 12;
    localparam int SYNC   = 2;
    localparam int AW     = $clog2(MEMB);
    localparam int REL    = SYNC + 1 + SETTLE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_rst_n = 1'b1, bod_en = 1'b0, bod_low = 1'b0, host_act = 1'b0;
    logic rd_valid = 1'b0, rd_err = 1'b0;
    logic [7:0] rd_data = '0;
    logic rd_req, mem_we, clk_fast_sel, pin_float, serial_sel, shut_down;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [NCORES-1:0] core_en;

    int n_run = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    boot_sequencer #(
        .NCORES(NCORES), .MEM_BYTES(MEMB), .SETTLE_CYC(SETTLE),
        .HOST_CYC(HOST), .SYNC_STAGES(SYNC)
    ) i_boot_sequencer (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .bod_en(bod_en),
        .bod_low(bod_low), .host_act(host_act), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .clk_fast_sel(clk_fast_sel), .core_en(core_en), .pin_float(pin_float),
        .serial_sel(serial_sel), .shut_down(shut_down)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_hold(input string tag);
        chk(core_en == '0, tag, int'(core_en), 0);
        chk(pin_float == 1'b1, tag, int'(pin_float), 1);
        chk(clk_fast_sel == 1'b0, tag, int'(clk_fast_sel), 0);
        chk(!rd_req && !mem_we && !serial_sel && !shut_down, tag,
            int'({rd_req, mem_we, serial_sel, shut_down}), 0);
    endtask

    // Counts edges from now (at a negedge) until clk_fast_sel is high
    task automatic count_to_fast(output int n);
        n = 0;
        while (!clk_fast_sel && n < 1000) begin
            @(posedge clk); n++; @(negedge clk);
        end
    endtask

    task automatic count_to_req(output int n);
        n = 0;
        while (!rd_req && n < 1000) begin
            @(posedge clk); n++; @(negedge clk);
        end
    endtask

    task automatic ext_reset_cycle(input string tag);
        ext_rst_n = 1'b0;
        repeat (SYNC + 2) @(posedge clk);
        @(negedge clk);
        chk_hold(tag);
        ext_rst_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic e);
        rd_valid = 1'b1; rd_data = d; rd_err = e;
        @(posedge clk); @(negedge clk);
        rd_valid = 1'b0; rd_err = 1'b0;
    endtask

    task automatic load_image(input int seed, input int gapmode);
        for (int i = 0; i < MEMB; i++) begin
            logic [7:0] exp_d;
            for (int g = 0; g < (i * gapmode) % 3; g++) begin
                @(posedge clk); @(negedge clk);
                chk(mem_we == 1'b0, "R6 idle gap", int'(mem_we), 0);
            end
            exp_d = 8'((i * 37 + seed) & 255);
            send_byte(exp_d, 1'b0);
            chk(mem_we == 1'b1, "R6 strobe", int'(mem_we), 1);
            chk(int'(mem_addr) == i, "R6 addr", int'(mem_addr), i);
            chk(mem_wdata == exp_d, "R6 data", int'(mem_wdata), int'(exp_d));
        end
        chk(core_en == '0 && rd_req == 1'b0, "R7 not yet released",
            int'({core_en, rd_req}), 0);
        @(posedge clk); @(negedge clk);
        chk(core_en == NCORES'(1), "R7 core0 released", int'(core_en), 1);
        chk(pin_float == 1'b0, "R7 pins driven", int'(pin_float), 0);
        chk(mem_we == 1'b0, "R6 no extra write", int'(mem_we), 0);
    endtask

    initial begin : main
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_hold("R1 power-on hold");
        // R3: brown-out flag ignored while detection disabled
        bod_low = 1'b1;
        rst = 1'b0;
        count_to_fast(n);
        chk(n == REL, "R2/R3 release timing with bod disabled", n, REL);
        bod_low = 1'b0;
        // R11: stray reader strobe during listen window
        rd_valid = 1'b1; rd_data = 8'hA5;
        @(posedge clk); @(negedge clk);
        rd_valid = 1'b0;
        chk(mem_we == 1'b0, "R11 stray strobe ignored", int'(mem_we), 0);
        begin
            int m;
            count_to_req(m);
            chk(m + 1 == HOST, "R5 listen window length", m + 1, HOST);
        end
        host_act = 1'b1;           // R5: late host activity ignored
        load_image(3, 1);
        chk(serial_sel == 1'b0, "R5 late host ignored", int'(serial_sel), 0);
        host_act = 1'b0;

        // R10: reset from run state
        ext_reset_cycle("R1/R10 ext reset from run");
        count_to_fast(n);
        chk(n == REL, "R10 restart timing", n, REL);
        count_to_req(n);
        for (int i = 0; i < 3; i++) send_byte(8'(i), 1'b0);
        ext_reset_cycle("R10 reset during load");
        count_to_fast(n);
        chk(n == REL, "R10 restart after load abort", n, REL);
        count_to_req(n);

        // R8: first byte not acknowledged
        send_byte(8'h00, 1'b1);
        chk(shut_down == 1'b1, "R8 shutdown", int'(shut_down), 1);
        chk(core_en == '0 && pin_float && !mem_we && !rd_req, "R8 safe state",
            int'({core_en, pin_float, mem_we, rd_req}), 1 << 2);

        // R9: later byte not acknowledged
        ext_reset_cycle("R1 reset from shutdown");
        count_to_fast(n);
        count_to_req(n);
        for (int i = 0; i < 5; i++) send_byte(8'(i + 9), 1'b0);
        send_byte(8'h00, 1'b1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(shut_down == 1'b1 && core_en == '0, "R9 late nack shutdown",
            int'({shut_down, core_en}), 1 << NCORES);

        // R3: brown-out with detection enabled
        bod_en = 1'b1; bod_low = 1'b1;
        repeat (SYNC + 2) @(posedge clk);
        @(negedge clk);
        chk_hold("R3 brown-out holds");
        bod_low = 1'b0;
        count_to_fast(n);
        chk(n == REL, "R3 release after brown-out", n, REL);
        bod_en = 1'b0;

        // R4/R5: host arrival sweep across the window boundary
        for (int d = 0; d <= HOST + 1; d++) begin
            bit exp_ser;
            ext_reset_cycle("R1 sweep reset");
            count_to_fast(n);
            repeat (d) @(posedge clk);
            @(negedge clk);
            host_act = 1'b1;
            repeat (HOST + 4) @(posedge clk);
            @(negedge clk);
            exp_ser = (d + SYNC <= HOST - 1);
            chk(serial_sel == exp_ser, exp_ser ? "R4 serial chosen" : "R5 load chosen",
                int'(serial_sel), int'(exp_ser));
            chk(rd_req == !exp_ser && pin_float == !exp_ser, "R4 pins and reader",
                int'({rd_req, pin_float}), exp_ser ? 0 : 3);
            host_act = 1'b0;
        end
        load_image(101, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule